// File: doc/BRIEF.md
# DMA Channel Interrupt Status and Mask Controller

This block collects the interrupt sources of one DMA channel and reduces them to a single level-sensitive interrupt line. Event pulses from the channel datapath latch bits in a twelve-bit status register. Software clears those bits by writing ones. A mask register holds one bit for each source. Software cannot write the mask directly. It changes the mask only through two strobe registers: one clears mask bits and the other sets them.

Two eight-bit accounting counters record completed source and destination descriptors whose interrupt flag was set. Each completion also sets a done bit in the status register. A counter that wraps raises an accounting error bit. Reading a counter clears it. Any access to an unmapped word offset sets the invalid-access status bit. All accesses are single-cycle: a read returns its data combinationally in the cycle it is presented, and any side effect of a read or write takes place at the following clock edge.

Top module: `dma_irq_ctl`

## Requirements
- R1: An event pulse `evt_set[i]` sets status bit i at the next clock edge. The status bit order, from bit 0 to bit 11, is: invalid access, source descriptor done, destination descriptor done, byte count overflow, source accounting error, destination accounting error, source descriptor read error, destination descriptor read error, data read error, data write error, transfer done, paused.
- R2: The status register is at word offset 0. Writing a one to any of bits 11:0 clears that bit. Bits 31:12 read as zero.
- R3: The mask register is at word offset 1 and reads 0xFFF after reset. Writes to offset 1 leave it unchanged.
- R4: A write to offset 2 (enable) clears the mask bits where the written value has ones. A write to offset 3 (disable) sets those mask bits. Offsets 2 and 3 both read as zero.
- R5: `irq` is high exactly when some status bit is set while its mask bit is clear. It follows each status or mask update one clock edge later.
- R6: A `src_done` pulse increments the source counter (offset 4) and sets status bit 1. A `dst_done` pulse increments the destination counter (offset 5) and sets status bit 2. An increment that wraps a counter from 255 to 0 also sets status bit 4 for the source counter or bit 5 for the destination counter.
- R7: The counters ignore writes, and a read of a counter clears it to zero.
- R8: A read or write at an unmapped offset (6 to 15) sets status bit 0. Such a read returns zero, and such a write changes no register.
- R9: When an event pulse and a software clear of the same status bit occur in the same cycle, the bit ends up set.
- R10: When a counter read and an increment of that counter occur in the same cycle, the read returns the old value and the counter becomes 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Word offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of a read |
| evt_set | input | 12 | Event pulses, one per status bit |
| src_done | input | 1 | Source descriptor completed with its interrupt flag set |
| dst_done | input | 1 | Destination descriptor completed with its interrupt flag set |
| irq | output | 1 | Level interrupt request |

## Verification
The bench builds the block with its defaults: an 8-bit counter width (CNT_W = 8) and a 4-bit word offset (ADDR_W = 4). With these values the full 255-to-0 wrap of a counter takes only a few hundred pulses. The 4-bit offset also leaves ten unmapped offsets available for invalid-access stimulus. Within these values the bench drives the same-cycle collisions of event with clear and of read with increment, and it checks that a masked source keeps `irq` low until the enable strobe is written.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;

    localparam int NUM_SRC = 12;
    localparam int DATA_W  = 32;

    // status bit positions that the block itself drives
    localparam int BIT_INV_ACC  = 0;
    localparam int BIT_SRC_DONE = 1;
    localparam int BIT_DST_DONE = 2;
    localparam int BIT_SRC_ERR  = 4;
    localparam int BIT_DST_ERR  = 5;

    typedef enum logic [2:0] {
        SEL_STATUS  = 3'd0,
        SEL_MASK    = 3'd1,
        SEL_ENABLE  = 3'd2,
        SEL_DISABLE = 3'd3,
        SEL_SRC_CNT = 3'd4,
        SEL_DST_CNT = 3'd5,
        SEL_NONE    = 3'd6
    } reg_sel_e;

    typedef struct packed {
        logic     rd;
        logic     wr;
        reg_sel_e sel;
    } access_t;

    function automatic reg_sel_e decode_offset(input logic [7:0] off);
        case (off)
            8'd0:    return SEL_STATUS;
            8'd1:    return SEL_MASK;
            8'd2:    return SEL_ENABLE;
            8'd3:    return SEL_DISABLE;
            8'd4:    return SEL_SRC_CNT;
            8'd5:    return SEL_DST_CNT;
            default: return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/dma_irq_status.sv
module dma_irq_status
    import dma_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] set_bits,
    input  logic [NUM_SRC-1:0] clr_bits,
    output logic [NUM_SRC-1:0] status
);
    // set has priority over a same-cycle clear
    always_ff @(posedge clk) begin
        if (rst) status <= '0;
        else     status <= (status & ~clr_bits) | set_bits;
    end
endmodule

// File: rtl/dma_irq_mask.sv
module dma_irq_mask
    import dma_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] unmask_bits,
    input  logic [NUM_SRC-1:0] mask_bits,
    output logic [NUM_SRC-1:0] mask
);
    always_ff @(posedge clk) begin
        if (rst) mask <= '1;
        else     mask <= (mask & ~unmask_bits) | mask_bits;
    end
endmodule

// File: rtl/dma_irq_acct.sv
module dma_irq_acct #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc,
    input  logic             rd_clr,
    output logic [CNT_W-1:0] count,
    output logic             wrap
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    // a read that meets an increment restarts the count at one
    assign wrap = inc && !rd_clr && (count == CNT_MAX);

    always_ff @(posedge clk) begin
        if (rst)         count <= '0;
        else if (inc)    count <= rd_clr ? CNT_ONE : count + CNT_ONE;
        else if (rd_clr) count <= '0;
    end
endmodule

// File: rtl/dma_irq_ctl.sv
module dma_irq_ctl
    import dma_irq_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int ADDR_W = 4
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_en,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [NUM_SRC-1:0]   evt_set,
    input  logic                 src_done,
    input  logic                 dst_done,
    output logic                 irq
);
    localparam int NUM_CNT = 2;

    access_t            acc;
    logic [NUM_SRC-1:0] status_q;
    logic [NUM_SRC-1:0] mask_q;
    logic [NUM_SRC-1:0] set_vec;
    logic [NUM_SRC-1:0] w1c_vec;
    logic [NUM_SRC-1:0] en_vec;
    logic [NUM_SRC-1:0] dis_vec;
    logic [NUM_SRC-1:0] wdata_lo;
    logic [NUM_CNT-1:0] cnt_inc;
    logic [NUM_CNT-1:0] cnt_rd;
    logic [NUM_CNT-1:0] cnt_wrap;
    logic [CNT_W-1:0]   cnt_val [NUM_CNT];
    logic               unused_wdata_hi;

    assign wdata_lo        = bus_wdata[NUM_SRC-1:0];
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:NUM_SRC];

    always_comb begin
        acc.rd  = bus_en && !bus_wr;
        acc.wr  = bus_en && bus_wr;
        acc.sel = decode_offset(8'(bus_addr));
    end

    assign w1c_vec = (acc.wr && acc.sel == SEL_STATUS)  ? wdata_lo : '0;
    assign en_vec  = (acc.wr && acc.sel == SEL_ENABLE)  ? wdata_lo : '0;
    assign dis_vec = (acc.wr && acc.sel == SEL_DISABLE) ? wdata_lo : '0;

    assign cnt_inc = {dst_done, src_done};
    assign cnt_rd  = {acc.rd && acc.sel == SEL_DST_CNT,
                      acc.rd && acc.sel == SEL_SRC_CNT};

    always_comb begin
        set_vec               = evt_set;
        set_vec[BIT_INV_ACC]  = evt_set[BIT_INV_ACC] || (bus_en && acc.sel == SEL_NONE);
        set_vec[BIT_SRC_DONE] = evt_set[BIT_SRC_DONE] || src_done;
        set_vec[BIT_DST_DONE] = evt_set[BIT_DST_DONE] || dst_done;
        set_vec[BIT_SRC_ERR]  = evt_set[BIT_SRC_ERR] || cnt_wrap[0];
        set_vec[BIT_DST_ERR]  = evt_set[BIT_DST_ERR] || cnt_wrap[1];
    end

    dma_irq_status status_i (
        .clk      (clk),
        .rst      (rst),
        .set_bits (set_vec),
        .clr_bits (w1c_vec),
        .status   (status_q)
    );

    dma_irq_mask mask_i (
        .clk         (clk),
        .rst         (rst),
        .unmask_bits (en_vec),
        .mask_bits   (dis_vec),
        .mask        (mask_q)
    );

    for (genvar c = 0; c < NUM_CNT; c++) begin : g_acct
        dma_irq_acct #(.CNT_W(CNT_W)) acct_i (
            .clk    (clk),
            .rst    (rst),
            .inc    (cnt_inc[c]),
            .rd_clr (cnt_rd[c]),
            .count  (cnt_val[c]),
            .wrap   (cnt_wrap[c])
        );
    end

    always_comb begin
        bus_rdata = '0;
        if (acc.rd) begin
            case (acc.sel)
                SEL_STATUS:  bus_rdata = DATA_W'(status_q);
                SEL_MASK:    bus_rdata = DATA_W'(mask_q);
                SEL_SRC_CNT: bus_rdata = DATA_W'(cnt_val[0]);
                SEL_DST_CNT: bus_rdata = DATA_W'(cnt_val[1]);
                default:     bus_rdata = '0;
            endcase
        end
    end

    assign irq = |(status_q & ~mask_q);

endmodule

// File: rtl/dma_irq_ctl_chk.sv
module dma_irq_ctl_chk
    import dma_irq_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int ADDR_W = 4
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_en,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [DATA_W-1:0]  bus_wdata,
    input logic [NUM_SRC-1:0] evt_set,
    input logic               src_done,
    input logic               irq,
    input logic [NUM_SRC-1:0] status_q,
    input logic [NUM_SRC-1:0] mask_q,
    input logic [CNT_W-1:0]   src_cnt
);
    logic wr_dis, wr_en, rd_src;
    assign wr_dis = bus_en && bus_wr && bus_addr == ADDR_W'(3);
    assign wr_en  = bus_en && bus_wr && bus_addr == ADDR_W'(2);
    assign rd_src = bus_en && !bus_wr && bus_addr == ADDR_W'(4);

    AST_MASK_AFTER_RESET: assert property (@(posedge clk) $fell(rst) |-> mask_q == '1); // R3

    AST_EVENT_WINS: assert property (@(posedge clk) disable iff (rst)
        (|evt_set) |=> ((status_q & $past(evt_set)) == $past(evt_set))); // R9

    AST_UNMASKED_EVT_IRQ: assert property (@(posedge clk) disable iff (rst)
        ((|(evt_set & ~mask_q)) && !wr_dis) |=> irq); // R5

    AST_ENABLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> ((mask_q & $past(bus_wdata[NUM_SRC-1:0])) == '0)); // R4

    AST_SRC_WRAP_ERR: assert property (@(posedge clk) disable iff (rst)
        (src_done && !rd_src && src_cnt == '1) |=> status_q[BIT_SRC_ERR]); // R6

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rd_src && !src_done) |=> src_cnt == '0); // R7

    AST_READ_INC_ONE: assert property (@(posedge clk) disable iff (rst)
        (rd_src && src_done) |=> src_cnt == CNT_W'(1)); // R10
endmodule

bind dma_irq_ctl dma_irq_ctl_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .bus_en    (bus_en),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .evt_set   (evt_set),
    .src_done  (src_done),
    .irq       (irq),
    .status_q  (status_q),
    .mask_q    (mask_q),
    .src_cnt   (cnt_val[0])
);

// File: tb/dma_irq_ctl_tb_top.sv
module dma_irq_ctl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int N_VEC = 24;

    logic        clk = 0;
    logic        rst = 1;
    logic        bus_en = 0, bus_wr = 0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [11:0] evt_set = '0;
    logic        src_done = 0, dst_done = 0;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_irq_ctl dut_i (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .evt_set(evt_set), .src_done(src_done), .dst_done(dst_done), .irq(irq)
    );

    // {is_read, offset, write data, expected read}
    localparam logic [68:0] VEC [0:N_VEC-1] = '{
        {1'b1, 4'd1,  32'h0,        32'h0000_0FFF},  // R3 mask after reset
        {1'b1, 4'd0,  32'h0,        32'h0000_0000},  // R2 status after reset
        {1'b0, 4'd1,  32'h0,        32'h0},
        {1'b1, 4'd1,  32'h0,        32'h0000_0FFF},  // R3 mask not writable
        {1'b0, 4'd2,  32'h0000_000F, 32'h0},
        {1'b1, 4'd1,  32'h0,        32'h0000_0FF0},  // R4 enable clears
        {1'b1, 4'd2,  32'h0,        32'h0},          // R4 enable reads zero
        {1'b1, 4'd3,  32'h0,        32'h0},          // R4 disable reads zero
        {1'b0, 4'd3,  32'h0000_0003, 32'h0},
        {1'b1, 4'd1,  32'h0,        32'h0000_0FF3},  // R4 disable sets
        {1'b1, 4'd0,  32'h0,        32'h0000_0000},  // R8 no stray status
        {1'b1, 4'd9,  32'h0,        32'h0},          // R8 unmapped read zero
        {1'b1, 4'd0,  32'h0,        32'h0000_0001},  // R8 invalid bit set
        {1'b0, 4'd0,  32'hFFFF_FFFF, 32'h0},
        {1'b1, 4'd0,  32'h0,        32'h0000_0000},  // R2 w1c clears
        {1'b0, 4'd12, 32'h0000_0FFF, 32'h0},
        {1'b1, 4'd1,  32'h0,        32'h0000_0FF3},  // R8 unmapped write no effect
        {1'b1, 4'd0,  32'h0,        32'h0000_0001},  // R8 invalid bit on write
        {1'b0, 4'd0,  32'h0000_0001, 32'h0},
        {1'b1, 4'd0,  32'h0,        32'h0000_0000},  // R2 single-bit clear
        {1'b0, 4'd4,  32'h0000_0055, 32'h0},
        {1'b1, 4'd4,  32'h0,        32'h0000_0000},  // R7 counter ignores write
        {1'b1, 4'd15, 32'h0,        32'h0},          // R8 top offset read zero
        {1'b0, 4'd0,  32'h0000_0001, 32'h0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_en = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 0; bus_wr = 0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_en = 1; bus_wr = 0; bus_addr = a;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_en = 0;
    endtask

    task automatic pulse_src(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); src_done = 1;
            @(negedge clk); src_done = 0;
        end
    endtask

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check("R5 irq low after reset", {31'b0, irq}, 32'h0);

        for (int i = 0; i < N_VEC; i++) begin
            if (VEC[i][68]) begin
                bus_read(VEC[i][67:64], v);
                check($sformatf("vector %0d", i), v, VEC[i][31:0]);
            end else begin
                bus_write(VEC[i][67:64], VEC[i][63:32]);
            end
        end

        // R1 R5: masked event latches but keeps irq low
        @(negedge clk); evt_set = 12'h400;
        @(negedge clk); evt_set = '0;
        check("R5 masked source irq", {31'b0, irq}, 32'h0);
        bus_read(4'd0, v);
        check("R1 transfer done bit 10", v, 32'h400);
        bus_write(4'd2, 32'h400);
        check("R5 irq after enable", {31'b0, irq}, 32'h1);
        bus_write(4'd0, 32'h400);
        check("R5 irq after clear", {31'b0, irq}, 32'h0);

        // R9: event and clear of bit 11 together
        @(negedge clk);
        bus_en = 1; bus_wr = 1; bus_addr = 4'd0; bus_wdata = 32'h800; evt_set = 12'h800;
        @(negedge clk);
        bus_en = 0; bus_wr = 0; evt_set = '0;
        bus_read(4'd0, v);
        check("R9 event wins over clear", v, 32'h800);
        bus_write(4'd0, 32'hFFF);

        // R6 R7: counting and clear on read
        pulse_src(3);
        bus_read(4'd4, v);
        check("R6 source count", v, 32'd3);
        bus_read(4'd4, v);
        check("R7 cleared by read", v, 32'd0);
        bus_read(4'd0, v);
        check("R6 source done bit 1", v, 32'h2);
        @(negedge clk); dst_done = 1;
        @(negedge clk); dst_done = 0;
        check("R5 unmasked dst done irq", {31'b0, irq}, 32'h1);
        bus_read(4'd5, v);
        check("R6 destination count", v, 32'd1);
        bus_read(4'd0, v);
        check("R6 dest done bit 2", v, 32'h6);
        bus_write(4'd0, 32'hFFF);

        // R6: wrap sets the source accounting error
        pulse_src(255);
        bus_read(4'd0, v);
        check("R6 no error before wrap", v & 32'h30, 32'h0);
        pulse_src(1);
        bus_read(4'd0, v);
        check("R6 error after wrap", v & 32'h30, 32'h10);
        bus_read(4'd4, v);
        check("R6 count wrapped to zero", v, 32'd0);

        // R10: read meets increment
        pulse_src(5);
        @(negedge clk);
        bus_en = 1; bus_wr = 0; bus_addr = 4'd4; src_done = 1;
        #1 v = bus_rdata;
        @(negedge clk);
        bus_en = 0; src_done = 0;
        check("R10 read returns old count", v, 32'd5);
        bus_read(4'd4, v);
        check("R10 count restarts at one", v, 32'd1);

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule